// File: doc/BRIEF.md
# GPIO bank register and interrupt unit

This unit holds the register state for one bank of general-purpose pins behind a simple register bus. Software drives the pins through an output register that is changed only by atomic write-one-to-set and write-one-to-clear accesses. It reads back the driven value or the synchronized pin levels. Each pin has its own configuration word, and bit 0 of that word chooses the pin's direction. The pin front end, which does debouncing and edge detection, delivers one-cycle event pulses per pin. The unit latches each pulse into a sticky status bit and raises a single bank interrupt while any latched pin is unmasked.

The bank's registers sit at fixed base offsets plus four times the bank index. The configuration words sit at 0x100 plus four times the global pin number (bank index times pin count plus local pin). A write-permission input from an external lock unit gates every write. Reads take one cycle: the data appears on the cycle after the read request.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset the output register is zero, every pin is an input (all output enables low), every configuration word reads 1, the mask reads all ones, the status reads zero and the bank interrupt is low.
- R2: A write to the set register (0x40 + 4·bank) drives high every pin whose data bit is 1 and leaves pins with 0 bits unchanged. The output-status register (0x00 + 4·bank) reads back the driven output register.
- R3: A write to the clear register (0x60 + 4·bank) drives low every pin whose data bit is 1 and leaves other pins unchanged. The set and clear registers read as zero.
- R4: Writing a pin's configuration word stores its low CTRL_W bits, and reads return them zero-extended. Bit 0 set to 1 makes the pin an input and bit 0 set to 0 makes it an output, and the pin's output enable is the inverse of bit 0.
- R5: The input-status register (0x20 + 4·bank) returns the pin input levels after a SYNC_STAGES-flop synchronizer.
- R6: An event pulse on a pin sets its status bit (0x80 + 4·bank) whatever the mask. The bit stays set until software writes 1 to it, and writing 0 leaves it alone.
- R7: When an event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Writing 1s to the mask register (0xA0 + 4·bank) masks those pins, and writing 1s to the mask-clear register (0xC0 + 4·bank) unmasks them. Both offsets read back the current mask.
- R9: The bank interrupt is high exactly while some status bit is set and its mask bit is clear.
- R10: While the write-permission input is low, writes to any register change nothing.
- R11: Addresses outside this bank's map read as zero. Writes to the two read-only status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| wr_allow | input | 1 | Write permission from the lock unit |
| pin_in | input | PINS | Raw pin input levels |
| pin_evt | input | PINS | One-cycle edge-event pulses from the pin front end |
| pin_out | output | PINS | Driven output levels |
| pin_oe | output | PINS | Output enables, 1 = pin drives |
| bank_irq | output | 1 | Bank interrupt request |

## Verification
An edge event from the front end and a software write-one clear of the interrupt status can land in the same clock cycle. When both target the same bit, the new event must not be lost. The bench provokes this by driving the event pulse on the same clock edge as the clear write, for bits that were already set and bits that were not. It judges the outcome from the status read back afterwards and from the bank interrupt level with the pin unmasked.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OUT_ST,
        SEL_IN_ST,
        SEL_OUT_SET,
        SEL_OUT_CLR,
        SEL_EVT_ST,
        SEL_MSK_SET,
        SEL_MSK_CLR,
        SEL_PIN_CFG
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } access_t;

    localparam int OFS_OUT_ST  = 32'h000;
    localparam int OFS_IN_ST   = 32'h020;
    localparam int OFS_OUT_SET = 32'h040;
    localparam int OFS_OUT_CLR = 32'h060;
    localparam int OFS_EVT_ST  = 32'h080;
    localparam int OFS_MSK_SET = 32'h0A0;
    localparam int OFS_MSK_CLR = 32'h0C0;
    localparam int OFS_PIN_CFG = 32'h100;

    localparam int DIR_BIT = 0;

    function automatic int bank_reg_addr(input int ofs, input int bank);
        return ofs + 4 * bank;
    endfunction

    function automatic int cfg_addr(input int bank, input int pins, input int pin);
        return OFS_PIN_CFG + 4 * (bank * pins + pin);
    endfunction

endpackage

// File: rtl/pbk_decode.sv
module pbk_decode
    import pbk_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int PINS     = 32,
    parameter int BANK_IDX = 1,
    parameter int PIDX_W   = $clog2(PINS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [PIDX_W-1:0] pin
);
    localparam logic [ADDR_W-1:0] A_OUT_ST  = ADDR_W'(bank_reg_addr(OFS_OUT_ST,  BANK_IDX));
    localparam logic [ADDR_W-1:0] A_IN_ST   = ADDR_W'(bank_reg_addr(OFS_IN_ST,   BANK_IDX));
    localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(bank_reg_addr(OFS_OUT_SET, BANK_IDX));
    localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(bank_reg_addr(OFS_OUT_CLR, BANK_IDX));
    localparam logic [ADDR_W-1:0] A_EVT_ST  = ADDR_W'(bank_reg_addr(OFS_EVT_ST,  BANK_IDX));
    localparam logic [ADDR_W-1:0] A_MSK_SET = ADDR_W'(bank_reg_addr(OFS_MSK_SET, BANK_IDX));
    localparam logic [ADDR_W-1:0] A_MSK_CLR = ADDR_W'(bank_reg_addr(OFS_MSK_CLR, BANK_IDX));
    localparam logic [ADDR_W-1:0] A_CFG_LO  = ADDR_W'(cfg_addr(BANK_IDX, PINS, 0));
    localparam logic [ADDR_W-1:0] A_CFG_SPAN = ADDR_W'(4 * PINS);

    logic [ADDR_W-1:0] rel;
    assign rel = addr - A_CFG_LO;
    assign pin = rel[PIDX_W+1:2];

    always_comb begin
        sel = SEL_NONE;
        case (addr)
            A_OUT_ST:  sel = SEL_OUT_ST;
            A_IN_ST:   sel = SEL_IN_ST;
            A_OUT_SET: sel = SEL_OUT_SET;
            A_OUT_CLR: sel = SEL_OUT_CLR;
            A_EVT_ST:  sel = SEL_EVT_ST;
            A_MSK_SET: sel = SEL_MSK_SET;
            A_MSK_CLR: sel = SEL_MSK_CLR;
            default: begin
                if (rel < A_CFG_SPAN && rel[1:0] == 2'b00)
                    sel = SEL_PIN_CFG;
            end
        endcase
    end

endmodule

// File: rtl/pbk_sync.sv
module pbk_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pbk_irq.sv
module pbk_irq #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] evt,
    input  logic            stat_clr_we,
    input  logic            msk_set_we,
    input  logic            msk_clr_we,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] status,
    output logic [PINS-1:0] mask,
    output logic            irq
);
    logic [PINS-1:0] clr_bits;
    assign clr_bits = stat_clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            // new events are ORed after the clear so they always win
            status <= (status & ~clr_bits) | evt;
            if (msk_set_we)
                mask <= mask | wdata;
            else if (msk_clr_we)
                mask <= mask & ~wdata;
        end
    end

    assign irq = |(status & ~mask);

    p_evt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));

    p_fall_needs_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (|($past(status) & ~status)) |-> $past(stat_clr_we));

    p_evt_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_clr_we && |(evt & wdata)) |=> ((status & $past(evt)) == $past(evt)));

    p_mask_set_r8: assert property (@(posedge clk) disable iff (rst)
        msk_set_we |=> ((mask & $past(wdata)) == $past(wdata)));

    p_mask_clr_r8: assert property (@(posedge clk) disable iff (rst)
        msk_clr_we |=> ((mask & $past(wdata)) == '0));

endmodule

// File: rtl/pbk_pins.sv
module pbk_pins
    import pbk_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int CTRL_W = 9,
    parameter int PIDX_W = $clog2(PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_set_we,
    input  logic              out_clr_we,
    input  logic              cfg_we,
    input  logic [PIDX_W-1:0] cfg_pin,
    input  logic [PINS-1:0]   out_data,
    input  logic [CTRL_W-1:0] cfg_data,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   dir_in,
    output logic [CTRL_W-1:0] cfg_rd
);
    logic [CTRL_W-1:0] cfg_q [PINS];

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_cfg
            always_ff @(posedge clk) begin
                if (rst)
                    cfg_q[p] <= CTRL_W'(1);
                else if (cfg_we && cfg_pin == PIDX_W'(p))
                    cfg_q[p] <= cfg_data;
            end
            assign dir_in[p] = cfg_q[p][DIR_BIT];
        end
    endgenerate

    assign cfg_rd = cfg_q[cfg_pin];

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '0;
        else if (out_set_we)
            out_q <= out_q | out_data;
        else if (out_clr_we)
            out_q <= out_q & ~out_data;
    end

    p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(out_set_we || out_clr_we) |=> $stable(out_q));

    p_out_clr_r3: assert property (@(posedge clk) disable iff (rst)
        out_clr_we |=> ((out_q & $past(out_data)) == '0));

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
    import pbk_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int CTRL_W      = 9,
    parameter int BANK_IDX    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wr_allow,
    input  logic [PINS-1:0]   pin_in,
    input  logic [PINS-1:0]   pin_evt,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              bank_irq
);
    localparam int PIDX_W = $clog2(PINS);

    access_t           acc;
    reg_sel_e          sel;
    logic [PIDX_W-1:0] pin_idx;
    logic [PINS-1:0]   in_sync, out_q, dir_in, status, mask;
    logic [CTRL_W-1:0] cfg_rd;

    pbk_decode #(.ADDR_W(ADDR_W), .PINS(PINS), .BANK_IDX(BANK_IDX), .PIDX_W(PIDX_W)) i_decode (
        .addr (bus_addr),
        .sel  (sel),
        .pin  (pin_idx)
    );

    assign acc.wr  = bus_req && bus_we && wr_allow;
    assign acc.rd  = bus_req && !bus_we;
    assign acc.sel = sel;

    pbk_sync #(.W(PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    pbk_pins #(.PINS(PINS), .CTRL_W(CTRL_W), .PIDX_W(PIDX_W)) i_pins (
        .clk        (clk),
        .rst        (rst),
        .out_set_we (acc.wr && acc.sel == SEL_OUT_SET),
        .out_clr_we (acc.wr && acc.sel == SEL_OUT_CLR),
        .cfg_we     (acc.wr && acc.sel == SEL_PIN_CFG),
        .cfg_pin    (pin_idx),
        .out_data   (bus_wdata[PINS-1:0]),
        .cfg_data   (bus_wdata[CTRL_W-1:0]),
        .out_q      (out_q),
        .dir_in     (dir_in),
        .cfg_rd     (cfg_rd)
    );

    pbk_irq #(.PINS(PINS)) i_irq (
        .clk         (clk),
        .rst         (rst),
        .evt         (pin_evt),
        .stat_clr_we (acc.wr && acc.sel == SEL_EVT_ST),
        .msk_set_we  (acc.wr && acc.sel == SEL_MSK_SET),
        .msk_clr_we  (acc.wr && acc.sel == SEL_MSK_CLR),
        .wdata       (bus_wdata[PINS-1:0]),
        .status      (status),
        .mask        (mask),
        .irq         (bank_irq)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~dir_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (acc.rd) begin
            case (acc.sel)
                SEL_OUT_ST:  bus_rdata <= DATA_W'(out_q);
                SEL_IN_ST:   bus_rdata <= DATA_W'(in_sync);
                SEL_EVT_ST:  bus_rdata <= DATA_W'(status);
                SEL_MSK_SET,
                SEL_MSK_CLR: bus_rdata <= DATA_W'(mask);
                SEL_PIN_CFG: bus_rdata <= DATA_W'(cfg_rd);
                default:     bus_rdata <= '0;
            endcase
        end
    end

    p_locked_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && !wr_allow) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> !bank_irq);

endmodule

// File: tb/test_pin_bank_ctrl.sv
`timescale 1ns/1ps
module test_pin_bank_ctrl;
    localparam int PINS = 32;
    localparam int BANK = 1;
    localparam logic [11:0] A_OUT  = 12'h004, A_IN   = 12'h024, A_SET = 12'h044,
                            A_CLR  = 12'h064, A_STAT = 12'h084, A_MSET = 12'h0A4,
                            A_MCLR = 12'h0C4;

    logic clk = 0, rst = 1, bus_req = 0, bus_we = 0, wr_allow = 1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [PINS-1:0] pin_in = '0, pin_evt = '0, pin_out, pin_oe;
    logic bank_irq;
    int errors = 0, checks = 0;
    logic [31:0] exp_out, exp_mask, exp_stat, rd;
    logic [8:0] exp_cfg [PINS];

    always #2.5 clk = ~clk;

    pin_bank_ctrl i_pin_bank_ctrl (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_allow(wr_allow), .pin_in(pin_in),
        .pin_evt(pin_evt), .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
    );

    function automatic logic [11:0] cfg_a(input int p);
        return 12'(32'h100 + 4 * (BANK * PINS + p));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_evt(input logic [11:0] a, input logic [31:0] d, input logic [31:0] e);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; pin_evt = e;
        @(negedge clk);
        bus_req = 0; bus_we = 0; pin_evt = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_evt(a, d, '0);
    endtask

    task automatic rdr(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        pin_evt = e;
        @(negedge clk);
        pin_evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        exp_out = '0; exp_mask = '1; exp_stat = '0;
        for (int p = 0; p < PINS; p++) exp_cfg[p] = 9'd1;
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", {31'd0, bank_irq}, 0);
        rdr(A_MSET, rd); chk("R1 mask", rd, 32'hFFFF_FFFF);
        rdr(A_STAT, rd); chk("R1 status", rd, 0);
        rdr(A_OUT, rd);  chk("R1 out status", rd, 0);
        rdr(cfg_a(0), rd);  chk("R1 cfg0", rd, 1);
        rdr(cfg_a(31), rd); chk("R1 cfg31", rd, 1);

        // R2 walking set, R3 walking clear
        for (int p = 0; p < PINS; p++) begin
            wr(A_SET, 32'd1 << p); exp_out |= 32'd1 << p;
            chk("R2 walking set", pin_out, exp_out);
        end
        for (int p = 0; p < PINS; p += 2) begin
            wr(A_CLR, 32'd1 << p); exp_out &= ~(32'd1 << p);
            chk("R3 walking clear", pin_out, exp_out);
        end
        wr(A_CLR, 32'hFFFF_0000); exp_out &= ~32'hFFFF_0000;
        chk("R3 clear pattern", pin_out, exp_out);
        wr(A_SET, 32'h5A00_0F0F); exp_out |= 32'h5A00_0F0F;
        chk("R2 set pattern", pin_out, exp_out);
        rdr(A_OUT, rd); chk("R2 out status readback", rd, exp_out);
        rdr(A_SET, rd); chk("R3 set reads zero", rd, 0);
        rdr(A_CLR, rd); chk("R3 clear reads zero", rd, 0);

        // R4 config words and direction
        for (int p = 0; p < PINS; p++) begin
            logic [31:0] d;
            d = 32'hABC0_0000 | 32'((p * 37) & 32'h1FE) | 32'(p % 2);
            wr(cfg_a(p), d); exp_cfg[p] = d[8:0];
        end
        begin
            logic [31:0] e_oe;
            for (int p = 0; p < PINS; p++) e_oe[p] = ~exp_cfg[p][0];
            chk("R4 output enables", pin_oe, e_oe);
        end
        for (int p = 0; p < PINS; p++) begin
            rdr(cfg_a(p), rd); chk("R4 cfg readback", rd, {23'd0, exp_cfg[p]});
        end
        wr(cfg_a(1), 32'h0); exp_cfg[1] = 9'd0;
        chk("R4 pin1 to output", {31'd0, pin_oe[1]}, 1);

        // R5 input sampling
        foreach (exp_cfg[i]) ;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] v;
            v = 32'h1357_9BDF * (k + 1) ^ 32'hF0F0_0F0F;
            @(negedge clk); pin_in = v;
            repeat (3) @(negedge clk);
            rdr(A_IN, rd); chk("R5 input status", rd, v);
        end

        // R6 events latch while masked
        for (int p = 0; p < PINS; p++) begin
            pulse(32'd1 << p); exp_stat |= 32'd1 << p;
            chk("R9 masked irq low", {31'd0, bank_irq}, 0);
        end
        rdr(A_STAT, rd); chk("R6 all latched", rd, exp_stat);
        wr(A_STAT, 32'h0000_FFFF); exp_stat &= ~32'h0000_FFFF;
        rdr(A_STAT, rd); chk("R6 w1c", rd, exp_stat);
        wr(A_STAT, 32'h0); 
        rdr(A_STAT, rd); chk("R6 zero write no effect", rd, exp_stat);

        // R8 / R9 unmask sweep
        for (int p = 0; p < PINS; p++) begin
            wr(A_MCLR, 32'd1 << p); exp_mask &= ~(32'd1 << p);
            chk("R9 irq unmasked", {31'd0, bank_irq}, {31'd0, exp_stat[p]});
            rdr(A_MCLR, rd); chk("R8 mask via clear offset", rd, exp_mask);
            wr(A_MSET, 32'd1 << p); exp_mask |= 32'd1 << p;
            chk("R9 irq remasked", {31'd0, bank_irq}, 0);
        end
        rdr(A_MSET, rd); chk("R8 mask via set offset", rd, exp_mask);

        // R7 event and clear in the same cycle
        wr(A_STAT, 32'hFFFF_FFFF); exp_stat = '0;
        wr(A_MCLR, 32'h0000_00F0); exp_mask &= ~32'h0000_00F0;
        chk("R9 irq after full clear", {31'd0, bank_irq}, 0);
        pulse(32'h0000_0030); exp_stat = 32'h30;
        wr_evt(A_STAT, 32'h0000_00F0, 32'h0000_0050); exp_stat = 32'h50;
        rdr(A_STAT, rd); chk("R7 event wins over clear", rd, exp_stat);
        chk("R7 irq kept", {31'd0, bank_irq}, 1);
        wr_evt(A_STAT, 32'h0000_0050, 32'h0000_0080); exp_stat = 32'h80;
        rdr(A_STAT, rd); chk("R7 other bit cleared", rd, exp_stat);

        // R10 locked writes
        wr_allow = 0;
        wr(A_SET, 32'hFFFF_FFFF); wr(A_CLR, 32'hFFFF_FFFF);
        chk("R10 outputs unchanged", pin_out, exp_out);
        wr(cfg_a(3), 32'h0);
        rdr(cfg_a(3), rd); chk("R10 cfg unchanged", rd, {23'd0, exp_cfg[3]});
        wr(A_STAT, 32'hFFFF_FFFF);
        rdr(A_STAT, rd); chk("R10 status unchanged", rd, exp_stat);
        wr(A_MCLR, 32'hFFFF_FFFF);
        rdr(A_MSET, rd); chk("R10 mask unchanged", rd, exp_mask);
        wr_allow = 1;

        // R11 address map edges
        rdr(12'h000, rd); chk("R11 other bank out", rd, 0);
        rdr(12'h100, rd); chk("R11 other bank cfg", rd, 0);
        rdr(12'h181, rd); chk("R11 misaligned cfg", rd, 0);
        rdr(12'h200, rd); chk("R11 past cfg range", rd, 0);
        wr(A_OUT, ~exp_out); chk("R11 out status read-only", pin_out, exp_out);
        wr(A_IN, 32'h0); rdr(A_IN, rd); chk("R11 in status read-only", rd, pin_in);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule